// File: doc/BRIEF.md
# Transmit Byte-Count Table Writer

This block turns transmit byte-count updates into 16-bit entries in a shared scheduler memory. Each update carries a queue number, a descriptor slot index and a frame length in bytes. The block takes updates on a valid/ready handshake and writes the entry through a simple write port that has a write enable and no backpressure. Every queue owns a table of 320 entries: 256 entries for the descriptor ring and 64 shadow entries after them. Each table starts on a fixed 1024-byte stride from a programmable base address.

When an update targets one of the first 64 slots, the block also writes the same entry into the shadow region at slot + 256. A reader can then fetch a window of up to 64 consecutive slots without wrapping at the ring end. A mirrored update uses two write cycles, the ring slot first and the shadow slot second. A byte count that does not fit the 12-bit field is clamped to 4095, and an error pulse is raised.

A small state machine sequences the work. Its states are `ST_IDLE` (no write on the port), `ST_PRIM` (ring write on the port, nothing pending), `ST_PRIM_M` (ring write on the port, shadow write pending) and `ST_MIRR` (shadow write on the port). The transitions are as follows. From `ST_IDLE`, `ST_PRIM` or `ST_MIRR`, an accepted update goes to `ST_PRIM_M` when its slot is below 64 and to `ST_PRIM` otherwise, and no accepted update goes to `ST_IDLE`. `ST_PRIM_M` always goes to `ST_MIRR`.

Top module: `bctw_top`

## Requirements
- R1: An update accepted at a rising edge (req_valid and req_ready both high) produces exactly one primary write, with wr_en high in the clock cycle that follows that edge.
- R2: wr_data bits [11:0] hold the byte count and bits [15:12] are always written as zero.
- R3: The primary write address is tbl_base + req_queue × 1024 + req_slot × 2, in bytes.
- R4: For slot indexes 0 to 63, a second write of identical data follows in the very next cycle at the primary address + 512 (slot + 256). For slot indexes 64 to 255, no second write is made.
- R5: A byte count above 4095 is written as 4095. sat_err is high for exactly the primary write cycle of that update and is never high on the shadow write.
- R6: req_ready is low only in the single cycle after a mirrored update is accepted, and nothing is accepted in that cycle. A request held across that cycle is taken once, on the next edge.
- R7: During reset, wr_en and sat_err are low and req_ready is high.
- R8: Updates for slots 64 to 255 are accepted on consecutive edges with no gap, and each gives one write per cycle.
- R9: wr_en stays low in every cycle that has neither an accepted update on the previous edge nor a pending shadow write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_base | input | 32 | Byte address of queue 0's table |
| req_valid | input | 1 | Update present |
| req_ready | output | 1 | Update can be taken this cycle |
| req_queue | input | 4 | Queue number 0..15 |
| req_slot | input | 8 | Descriptor slot index 0..255 |
| req_bytes | input | 16 | Frame length in bytes |
| wr_en | output | 1 | Memory write strobe, one cycle per write |
| wr_addr | output | 32 | Byte address of the entry |
| wr_data | output | 16 | Entry value |
| sat_err | output | 1 | Byte count was clamped, aligned with the primary write |

## Verification
The primary write of an update is due one cycle after the edge that accepts it. The shadow write of a mirrored update is due two cycles after that edge, and req_ready drops for exactly the one cycle in between. The bench stamps every expected write into a slot indexed by its due cycle number when it sees its own request accepted. At each falling edge it compares the port against that slot, and an empty slot demands that wr_en is low. It also compares req_ready against the cycle number it predicted for the low cycle, before deciding whether its request is taken.

// File: rtl/bctw_pkg.sv
package bctw_pkg;

    // bytes occupied by one table entry
    localparam int ENTRY_BYTES = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIM   = 2'd1,
        ST_PRIM_M = 2'd2,
        ST_MIRR   = 2'd3
    } bct_state_e;

endpackage

// File: rtl/bctw_entry_fmt.sv
// Packs a byte count into a table entry, clamping to the field range.
module bctw_entry_fmt #(
    parameter int IN_W    = 16,
    parameter int CNT_W   = 12,
    parameter int ENTRY_W = 16
) (
    input  logic [IN_W-1:0]    bytes_in,
    output logic [ENTRY_W-1:0] entry_out,
    output logic               clamped
);
    localparam int PAD_W = ENTRY_W - CNT_W;

    generate
        if (IN_W > CNT_W) begin : g_clamp
            localparam logic [IN_W-1:0] CNT_MAX = IN_W'((1 << CNT_W) - 1);
            logic [CNT_W-1:0] field;
            always_comb begin
                clamped = (bytes_in > CNT_MAX);
                field   = clamped ? CNT_MAX[CNT_W-1:0] : bytes_in[CNT_W-1:0];
            end
            assign entry_out = {{PAD_W{1'b0}}, field};
        end else begin : g_fit
            assign clamped   = 1'b0;
            assign entry_out = ENTRY_W'(bytes_in);
        end
    endgenerate

endmodule

// File: rtl/bctw_addr_gen.sv
// Computes primary and shadow byte addresses and whether a shadow copy is due.
module bctw_addr_gen #(
    parameter int ADDR_W       = 32,
    parameter int NUM_QUEUES   = 16,
    parameter int RING_SLOTS   = 256,
    parameter int MIRROR_SLOTS = 64,
    parameter int STRIDE_BYTES = 1024,
    localparam int Q_W         = $clog2(NUM_QUEUES),
    localparam int SLOT_W      = $clog2(RING_SLOTS)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [Q_W-1:0]    queue,
    input  logic [SLOT_W-1:0] slot,
    output logic [ADDR_W-1:0] prim_addr,
    output logic [ADDR_W-1:0] mirr_addr,
    output logic              need_mirror
);
    import bctw_pkg::*;

    localparam int  ENTRY_SH   = $clog2(ENTRY_BYTES);
    localparam bit  STRIDE_P2  = ((STRIDE_BYTES & (STRIDE_BYTES - 1)) == 0);
    localparam int  STRIDE_SH  = $clog2(STRIDE_BYTES);
    localparam logic [SLOT_W:0]   MIRR_LIM = (SLOT_W + 1)'(MIRROR_SLOTS);
    localparam logic [ADDR_W-1:0] MIRR_OFS = ADDR_W'(RING_SLOTS * ENTRY_BYTES);

    logic [ADDR_W-1:0] queue_ofs;
    logic [ADDR_W-1:0] slot_ofs;

    generate
        if (STRIDE_P2) begin : g_shift
            assign queue_ofs = ADDR_W'(queue) << STRIDE_SH;
        end else begin : g_mult
            assign queue_ofs = ADDR_W'(queue) * ADDR_W'(STRIDE_BYTES);
        end
    endgenerate

    always_comb begin
        slot_ofs    = ADDR_W'(slot) << ENTRY_SH;
        prim_addr   = base + queue_ofs + slot_ofs;
        mirr_addr   = prim_addr + MIRR_OFS;
        need_mirror = ({1'b0, slot} < MIRR_LIM);
    end

endmodule

// File: rtl/bctw_wr_fsm.sv
// Sequences primary and shadow writes and drives the memory port.
module bctw_wr_fsm #(
    parameter int ADDR_W  = 32,
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               need_mirror,
    input  logic [ADDR_W-1:0]  prim_addr,
    input  logic [ADDR_W-1:0]  mirr_addr,
    input  logic [ENTRY_W-1:0] entry,
    input  logic               clamped,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [ENTRY_W-1:0] wr_data,
    output logic               sat_err
);
    import bctw_pkg::*;

    bct_state_e        state_q;
    bct_state_e        state_d;
    logic              accept;
    logic [ADDR_W-1:0] mirr_addr_q;

    assign req_ready = (state_q != ST_PRIM_M);
    assign accept    = req_valid && req_ready;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PRIM, ST_MIRR: begin
                if (accept) state_d = need_mirror ? ST_PRIM_M : ST_PRIM;
                else        state_d = ST_IDLE;
            end
            ST_PRIM_M: state_d = ST_MIRR;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered port outputs; data is held for the shadow write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            sat_err     <= 1'b0;
            mirr_addr_q <= '0;
        end else begin
            wr_en   <= 1'b0;
            sat_err <= 1'b0;
            if (accept) begin
                wr_en       <= 1'b1;
                wr_addr     <= prim_addr;
                wr_data     <= entry;
                sat_err     <= clamped;
                mirr_addr_q <= mirr_addr;
            end else if (state_q == ST_PRIM_M) begin
                wr_en   <= 1'b1;
                wr_addr <= mirr_addr_q;
            end
        end
    end

endmodule

// File: rtl/bctw_top.sv
// Byte-count table writer: top level.
module bctw_top #(
    parameter int ADDR_W       = 32,
    parameter int NUM_QUEUES   = 16,
    parameter int RING_SLOTS   = 256,
    parameter int MIRROR_SLOTS = 64,
    parameter int STRIDE_BYTES = 1024,
    parameter int BYTES_W      = 16,
    parameter int CNT_W        = 12,
    parameter int ENTRY_W      = 16,
    localparam int Q_W         = $clog2(NUM_QUEUES),
    localparam int SLOT_W      = $clog2(RING_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [Q_W-1:0]     req_queue,
    input  logic [SLOT_W-1:0]  req_slot,
    input  logic [BYTES_W-1:0] req_bytes,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [ENTRY_W-1:0] wr_data,
    output logic               sat_err
);
    logic [ADDR_W-1:0]  prim_addr;
    logic [ADDR_W-1:0]  mirr_addr;
    logic               need_mirror;
    logic [ENTRY_W-1:0] entry;
    logic               clamped;

    bctw_entry_fmt #(
        .IN_W    (BYTES_W),
        .CNT_W   (CNT_W),
        .ENTRY_W (ENTRY_W)
    ) u_fmt (
        .bytes_in  (req_bytes),
        .entry_out (entry),
        .clamped   (clamped)
    );

    bctw_addr_gen #(
        .ADDR_W       (ADDR_W),
        .NUM_QUEUES   (NUM_QUEUES),
        .RING_SLOTS   (RING_SLOTS),
        .MIRROR_SLOTS (MIRROR_SLOTS),
        .STRIDE_BYTES (STRIDE_BYTES)
    ) u_addr (
        .base        (tbl_base),
        .queue       (req_queue),
        .slot        (req_slot),
        .prim_addr   (prim_addr),
        .mirr_addr   (mirr_addr),
        .need_mirror (need_mirror)
    );

    bctw_wr_fsm #(
        .ADDR_W  (ADDR_W),
        .ENTRY_W (ENTRY_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .need_mirror (need_mirror),
        .prim_addr   (prim_addr),
        .mirr_addr   (mirr_addr),
        .entry       (entry),
        .clamped     (clamped),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sat_err     (sat_err)
    );

endmodule

// File: rtl/bctw_checker.sv
// Port-level properties of the byte-count table writer.
module bctw_checker #(
    parameter int ADDR_W   = 32,
    parameter int ENTRY_W  = 16,
    parameter int CNT_W    = 12,
    parameter int MIRR_OFS = 512
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [ENTRY_W-1:0] wr_data,
    input logic               sat_err
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(MIRR_OFS);

    AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> wr_en); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[ENTRY_W-1:CNT_W] == '0)); // R2

    AST_MIRROR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !req_ready) |=> (wr_en && (wr_addr == $past(wr_addr) + OFS))); // R4

    AST_MIRROR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !req_ready) |=> $stable(wr_data)); // R4

    AST_ERR_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        sat_err |-> (wr_en && (wr_data[CNT_W-1:0] == '1))); // R5

    AST_ERR_NOT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !sat_err); // R5

    AST_READY_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready); // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> !wr_en); // R9

endmodule

bind bctw_top bctw_checker #(
    .ADDR_W   (ADDR_W),
    .ENTRY_W  (ENTRY_W),
    .CNT_W    (CNT_W),
    .MIRR_OFS (RING_SLOTS * 2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sat_err   (sat_err)
);

// File: tb/tb_bctw_top.sv
module tb_bctw_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_queue = '0;
    logic [7:0]  req_slot = '0;
    logic [15:0] req_bytes = '0;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [15:0] wr_data;
    logic        sat_err;

    always #2 clk = ~clk;  // 250 MHz

    bctw_top dut (
        .clk (clk), .rst_n (rst_n), .tbl_base (tbl_base),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_queue (req_queue), .req_slot (req_slot), .req_bytes (req_bytes),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .sat_err (sat_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int low_cyc  = -1;
    int mon_k;
    bit mon_on   = 1'b0;

    logic        exp_v [8];
    logic [31:0] exp_a [8];
    logic [15:0] exp_d [8];
    logic        exp_e [8];
    string       exp_t [8];

    always @(posedge clk) cyc <= cyc + 1;

    // watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // cycle-exact write monitor
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            mon_k = cyc % 8;
            n_checks++;
            if (exp_v[mon_k]) begin
                if (!wr_en || wr_addr !== exp_a[mon_k] || wr_data !== exp_d[mon_k]
                    || sat_err !== exp_e[mon_k]) begin
                    n_fail++;
                    $display("FAIL %s: en=%b addr=%h data=%h err=%b expected en=1 addr=%h data=%h err=%b",
                             exp_t[mon_k], wr_en, wr_addr, wr_data, sat_err,
                             exp_a[mon_k], exp_d[mon_k], exp_e[mon_k]);
                end
                exp_v[mon_k] = 1'b0;
            end else if (wr_en || sat_err) begin
                n_fail++;
                $display("FAIL R9: en=%b err=%b addr=%h expected no write", wr_en, sat_err, wr_addr);
            end
        end
    end

    function automatic logic [15:0] pat(int q, int s);
        return 16'((q * 997 + s * 61 + 7) % 4700);
    endfunction

    task automatic send(input int q, input int s, input logic [15:0] b);
        logic [31:0] pa;
        logic [15:0] d;
        logic        e;
        int          k;
        @(negedge clk); #1;
        req_valid = 1'b1;
        req_queue = 4'(q);
        req_slot  = 8'(s);
        req_bytes = b;
        forever begin
            n_checks++;
            if (req_ready !== (cyc != low_cyc)) begin
                n_fail++;
                $display("FAIL R6 R8: ready=%b expected %b at cycle %0d", req_ready, (cyc != low_cyc), cyc);
            end
            if (req_ready) break;
            @(negedge clk); #1;
        end
        pa = tbl_base + 32'(q) * 32'd1024 + 32'(s) * 32'd2;
        e  = (b > 16'd4095);
        d  = e ? 16'd4095 : b;
        k  = (cyc + 1) % 8;
        exp_v[k] = 1'b1; exp_a[k] = pa; exp_d[k] = d; exp_e[k] = e;
        exp_t[k] = e ? "R5" : "R1 R2 R3";
        if (s < 64) begin
            k = (cyc + 2) % 8;
            exp_v[k] = 1'b1; exp_a[k] = pa + 32'd512; exp_d[k] = d; exp_e[k] = 1'b0;
            exp_t[k] = "R4";
            low_cyc = cyc + 1;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk); #1;
        req_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            exp_v[i] = 1'b0; exp_a[i] = '0; exp_d[i] = '0; exp_e[i] = 1'b0; exp_t[i] = "";
        end
        repeat (3) @(negedge clk);
        // R7: reset values
        n_checks++;
        if (wr_en !== 1'b0 || sat_err !== 1'b0 || req_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R7: en=%b err=%b ready=%b expected 0 0 1", wr_en, sat_err, req_ready);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (2) @(negedge clk);

        // sweep of every queue and slot, gaps now and then
        for (int q = 0; q < 16; q++) begin
            for (int s = 0; s < 256; s++) begin
                send(q, s, pat(q, s));
                if ((q * 256 + s) % 37 == 36) idle(2);
            end
        end
        idle(3);

        // boundary cases with a new base
        tbl_base = 32'h00A0_3000;
        send(15, 255, 16'hFFFF);  // R5 clamp, no mirror
        send(0, 0, 16'd4096);     // R5 clamp, R4 mirror
        send(7, 63, 16'd4095);    // R4 last mirrored slot
        send(7, 64, 16'd0);       // R4 first unmirrored slot
        send(3, 0, 16'd4095);
        send(9, 200, 16'd1);      // R8 back to back
        send(9, 201, 16'd2);
        idle(6);

        mon_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule